// File: doc/BRIEF.md
# Add-Type Reservation Station Array

This block holds up to three pending add-type operations in front of one pipelined adder. An operation is issued into the lowest-numbered free station together with its two operands. For each operand, the issuer supplies either the value itself or the 4-bit tag of the producer that will broadcast it. While an operand is pending, the station watches the shared result bus and takes the broadcast data when the tag matches. A station whose two operands are both present is handed to the adder. When several are ready, the lowest-numbered station goes first, and at most one goes per cycle. Operations therefore start in the order their operands arrive rather than the order they were issued.

Each station is known by its own tag: station 0 is tag 10, station 1 is tag 11, station 2 is tag 12. From the cycle it is dispatched, a station asks for the result bus, which gives the arbiter its two-cycle lead time. The station stays occupied until its own tag appears on the bus, since that broadcast is the grant of its result. The arithmetic and the bus arbitration lie outside this block.

Every station runs one state machine with four states. FREE is empty and available. WAIT is occupied with an operand still pending. READY holds both operands and is waiting for the adder. EXEC has been dispatched and is requesting the bus. The transitions are:
- FREE to WAIT on issue when an operand is still pending.
- FREE to READY on issue when both operands are present, counting a same-cycle bus match.
- WAIT to READY when the last operand is captured.
- READY to EXEC when the station is selected for dispatch.
- EXEC to FREE when its own tag is broadcast.

Top module: `rs_array`

## Requirements
- R1: After reset all stations are empty: `issue_free`=1, `issue_tag`=10, `disp_valid`=0 and `bus_req`=0.
- R2: An accepted issue (`issue_valid` with `issue_free`=1) goes to the lowest-numbered free station. `issue_tag` shows that station's tag, which is 10 plus the station index. `issue_free` is 0 while all three stations are occupied.
- R3: `issue_valid` while `issue_free`=0 is ignored: no station changes.
- R4: An operand issued with its ready flag set takes the issue data directly.
- R5: A pending operand captures `bus_data` at the first clock edge where `bus_valid`=1 and `bus_tag` equals the operand's tag. Each of the two operands is handled independently and in either order.
- R6: A bus match in the same cycle as the issue is captured, so the operand is not left pending.
- R7: A station becomes dispatchable in the cycle after its last operand arrives. `disp_valid`=1 then, with `disp_tag` giving the station tag, `disp_op` the operation, `disp_sink` the sink operand and `disp_src` the source operand.
- R8: Among ready stations, the lowest-numbered one is dispatched. Only one station is dispatched per cycle, and each ready station is dispatched exactly once.
- R9: `bus_req[i]` is high from station i's dispatch cycle until station i's own tag is broadcast. The station is free in the cycle after that broadcast.
- R10: A broadcast whose tag matches no pending operand changes no operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue request |
| issue_op | input | OP_W | Operation code |
| issue_sink_rdy | input | 1 | Sink operand value is present |
| issue_sink_tag | input | TAG_W | Producer tag of the sink operand when pending |
| issue_sink_data | input | DATA_W | Sink operand value |
| issue_src_rdy | input | 1 | Source operand value is present |
| issue_src_tag | input | TAG_W | Producer tag of the source operand when pending |
| issue_src_data | input | DATA_W | Source operand value |
| issue_free | output | 1 | A station is free to accept an issue |
| issue_tag | output | TAG_W | Tag of the station the next issue takes |
| bus_valid | input | 1 | Result bus broadcast valid |
| bus_tag | input | TAG_W | Tag of the broadcasting producer |
| bus_data | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | An operation starts in the adder this cycle |
| disp_op | output | OP_W | Operation of the dispatched station |
| disp_tag | output | TAG_W | Tag of the dispatched station |
| disp_sink | output | DATA_W | Sink operand to the adder |
| disp_src | output | DATA_W | Source operand to the adder |
| bus_req | output | NUM_STN | Per-station result bus request |

## Verification
The issue and bus inputs are driven just after a falling edge. The station registers take them at the next rising edge. `issue_free`, `issue_tag`, the dispatch outputs and `bus_req` are combinational from those registers, so each result is due one cycle after its stimulus. For example, an issue with both operands present shows on `disp_valid` one cycle later, and that station's `bus_req` stays high until one cycle after its own tag is broadcast. Each cycle, the bench samples all outputs one nanosecond after it drives the inputs, which is well before the next rising edge. It compares them with a per-station model that advances at that edge from the same inputs.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2,
        ST_EXEC  = 2'd3
    } stn_state_e;

endpackage

// File: rtl/rs_pick.sv
`timescale 1ns/1ps
module rs_pick #(
    parameter int N     = 3,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        gnt = '0;
        idx = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rs_slot.sv
`timescale 1ns/1ps
module rs_slot #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_rdy,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_data,
    input  logic              snoop,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic              rdy_nxt,
    output logic [DATA_W-1:0] data
);

    logic              rdy_q;
    logic [TAG_W-1:0]  tag_q;
    logic [TAG_W-1:0]  tag_nxt;
    logic [DATA_W-1:0] data_nxt;

    always_comb begin
        rdy_nxt  = rdy_q;
        tag_nxt  = tag_q;
        data_nxt = data;
        if (load) begin
            tag_nxt = in_tag;
            if (in_rdy) begin
                rdy_nxt  = 1'b1;
                data_nxt = in_data;
            end else if (bus_valid && bus_tag == in_tag) begin
                rdy_nxt  = 1'b1;
                data_nxt = bus_data;
            end else begin
                rdy_nxt  = 1'b0;
            end
        end else if (snoop && !rdy_q && bus_valid && bus_tag == tag_q) begin
            rdy_nxt  = 1'b1;
            data_nxt = bus_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
            tag_q <= '0;
            data  <= '0;
        end else begin
            rdy_q <= rdy_nxt;
            tag_q <= tag_nxt;
            data  <= data_nxt;
        end
    end

    // R5: a matching broadcast is taken into a pending operand
    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop && !rdy_q && bus_valid && bus_tag == tag_q)
        |=> (rdy_q && data == $past(bus_data)));

    // R5: a captured operand is held until the next load
    assert_slot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_q && !load) |=> (rdy_q && $stable(data)));

    // R10: a non-matching broadcast leaves a pending operand pending
    assert_no_false_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !rdy_q && !(bus_valid && bus_tag == tag_q)) |=> !rdy_q);

endmodule

// File: rtl/rs_station.sv
`timescale 1ns/1ps
module rs_station
    import rs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int OP_W   = 2,
    parameter int MY_TAG = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [OP_W-1:0]   in_op,
    input  logic              in_sink_rdy,
    input  logic [TAG_W-1:0]  in_sink_tag,
    input  logic [DATA_W-1:0] in_sink_data,
    input  logic              in_src_rdy,
    input  logic [TAG_W-1:0]  in_src_tag,
    input  logic [DATA_W-1:0] in_src_data,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              go,
    output logic              is_free,
    output logic              is_ready,
    output logic              req,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] sink_data,
    output logic [DATA_W-1:0] src_data
);

    localparam logic [TAG_W-1:0] OWN_TAG = TAG_W'(MY_TAG);

    stn_state_e state_q, state_d;
    logic       snoop;
    logic       sink_nxt, src_nxt;
    logic       own_hit;

    assign snoop   = (state_q == ST_WAIT);
    assign own_hit = bus_valid && (bus_tag == OWN_TAG);

    rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) sink_i (
        .clk(clk), .rst_n(rst_n), .load(load),
        .in_rdy(in_sink_rdy), .in_tag(in_sink_tag), .in_data(in_sink_data),
        .snoop(snoop), .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .rdy_nxt(sink_nxt), .data(sink_data)
    );

    rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) src_i (
        .clk(clk), .rst_n(rst_n), .load(load),
        .in_rdy(in_src_rdy), .in_tag(in_src_tag), .in_data(in_src_data),
        .snoop(snoop), .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .rdy_nxt(src_nxt), .data(src_data)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE:  if (load) state_d = (sink_nxt && src_nxt) ? ST_READY : ST_WAIT;
            ST_WAIT:  if (sink_nxt && src_nxt) state_d = ST_READY;
            ST_READY: if (go) state_d = ST_EXEC;
            ST_EXEC:  if (own_hit) state_d = ST_FREE;
            default:  state_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            op      <= '0;
        end else begin
            state_q <= state_d;
            if (load) op <= in_op;
        end
    end

    always_comb begin
        is_free  = 1'b0;
        is_ready = 1'b0;
        req      = 1'b0;
        unique case (state_q)
            ST_FREE:  is_free  = 1'b1;
            ST_WAIT:  ;
            ST_READY: begin
                is_ready = 1'b1;
                req      = go;
            end
            ST_EXEC:  req = 1'b1;
            default:  ;
        endcase
    end

    // R2: the array only loads an empty station
    assert_load_only_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (state_q == ST_FREE));

    // R7: a ready station waits until it is picked
    assert_ready_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && !go) |=> (state_q == ST_READY));

    // R9: a dispatched station keeps asking until its own tag is broadcast
    assert_exec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && !own_hit) |=> (state_q == ST_EXEC && req));

    // R9: the broadcast of its own tag releases the station
    assert_exec_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && own_hit) |=> is_free);

endmodule

// File: rtl/rs_array.sv
`timescale 1ns/1ps
module rs_array #(
    parameter int NUM_STN  = 3,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 32,
    parameter int OP_W     = 2,
    parameter int BASE_TAG = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    input  logic [OP_W-1:0]    issue_op,
    input  logic               issue_sink_rdy,
    input  logic [TAG_W-1:0]   issue_sink_tag,
    input  logic [DATA_W-1:0]  issue_sink_data,
    input  logic               issue_src_rdy,
    input  logic [TAG_W-1:0]   issue_src_tag,
    input  logic [DATA_W-1:0]  issue_src_data,
    output logic               issue_free,
    output logic [TAG_W-1:0]   issue_tag,
    input  logic               bus_valid,
    input  logic [TAG_W-1:0]   bus_tag,
    input  logic [DATA_W-1:0]  bus_data,
    output logic               disp_valid,
    output logic [OP_W-1:0]    disp_op,
    output logic [TAG_W-1:0]   disp_tag,
    output logic [DATA_W-1:0]  disp_sink,
    output logic [DATA_W-1:0]  disp_src,
    output logic [NUM_STN-1:0] bus_req
);

    localparam int IDX_W = (NUM_STN > 1) ? $clog2(NUM_STN) : 1;
    localparam logic [TAG_W-1:0] TAG0 = TAG_W'(BASE_TAG);

    logic [NUM_STN-1:0] free_v, ready_v, load_v, go_v;
    logic [NUM_STN-1:0] alloc_gnt;
    logic [IDX_W-1:0]   alloc_idx, disp_idx;
    logic               alloc_any;
    logic [OP_W-1:0]    stn_op   [NUM_STN];
    logic [DATA_W-1:0]  stn_sink [NUM_STN];
    logic [DATA_W-1:0]  stn_src  [NUM_STN];

    rs_pick #(.N(NUM_STN), .IDX_W(IDX_W)) alloc_pick_i (
        .req(free_v), .gnt(alloc_gnt), .idx(alloc_idx), .any(alloc_any)
    );

    rs_pick #(.N(NUM_STN), .IDX_W(IDX_W)) disp_pick_i (
        .req(ready_v), .gnt(go_v), .idx(disp_idx), .any(disp_valid)
    );

    assign load_v     = issue_valid ? alloc_gnt : '0;
    assign issue_free = alloc_any;
    assign issue_tag  = TAG0 + TAG_W'(alloc_idx);
    assign disp_tag   = TAG0 + TAG_W'(disp_idx);

    for (genvar g = 0; g < NUM_STN; g++) begin : g_stn
        rs_station #(
            .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .MY_TAG(BASE_TAG + g)
        ) stn_i (
            .clk(clk), .rst_n(rst_n), .load(load_v[g]),
            .in_op(issue_op),
            .in_sink_rdy(issue_sink_rdy), .in_sink_tag(issue_sink_tag),
            .in_sink_data(issue_sink_data),
            .in_src_rdy(issue_src_rdy), .in_src_tag(issue_src_tag),
            .in_src_data(issue_src_data),
            .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
            .go(go_v[g]),
            .is_free(free_v[g]), .is_ready(ready_v[g]), .req(bus_req[g]),
            .op(stn_op[g]), .sink_data(stn_sink[g]), .src_data(stn_src[g])
        );
    end

    always_comb begin
        disp_op   = '0;
        disp_sink = '0;
        disp_src  = '0;
        for (int i = 0; i < NUM_STN; i++) begin
            if (go_v[i]) begin
                disp_op   = stn_op[i];
                disp_sink = stn_sink[i];
                disp_src  = stn_src[i];
            end
        end
    end

    // R8: a station is never handed to the adder twice in a row
    assert_no_redispatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> (!disp_valid || disp_tag != $past(disp_tag)));

    // R9: the dispatched station raises its bus request in the same cycle
    assert_req_on_dispatch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (bus_req != '0));

    // R3: with nothing free, an issue cannot change the station count
    assert_full_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_free && !bus_valid) |=> !issue_free);

endmodule

// File: tb/rs_array_tb_top.sv
`timescale 1ns/1ps
module rs_array_tb_top;

    localparam int NS = 3, TW = 4, DW = 32, OW = 2, BT = 10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          issue_valid, issue_sink_rdy, issue_src_rdy;
    logic [OW-1:0] issue_op;
    logic [TW-1:0] issue_sink_tag, issue_src_tag;
    logic [DW-1:0] issue_sink_data, issue_src_data;
    logic          issue_free;
    logic [TW-1:0] issue_tag;
    logic          bus_valid;
    logic [TW-1:0] bus_tag;
    logic [DW-1:0] bus_data;
    logic          disp_valid;
    logic [OW-1:0] disp_op;
    logic [TW-1:0] disp_tag;
    logic [DW-1:0] disp_sink, disp_src;
    logic [NS-1:0] bus_req;

    rs_array #(.NUM_STN(NS), .TAG_W(TW), .DATA_W(DW), .OP_W(OW), .BASE_TAG(BT)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_sink_rdy(issue_sink_rdy), .issue_sink_tag(issue_sink_tag),
        .issue_sink_data(issue_sink_data),
        .issue_src_rdy(issue_src_rdy), .issue_src_tag(issue_src_tag),
        .issue_src_data(issue_src_data),
        .issue_free(issue_free), .issue_tag(issue_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_tag(disp_tag),
        .disp_sink(disp_sink), .disp_src(disp_src), .bus_req(bus_req)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model: 0 free, 1 wait, 2 ready, 3 exec
    int            m_st  [NS];
    logic [OW-1:0] m_op  [NS];
    logic          m_ar  [NS], m_br [NS];
    logic [TW-1:0] m_at  [NS], m_bt [NS];
    logic [DW-1:0] m_ad  [NS], m_bd [NS];

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_alloc();
        for (int i = 0; i < NS; i++) if (m_st[i] == 0) return i;
        return -1;
    endfunction

    function automatic int m_dsel();
        for (int i = 0; i < NS; i++) if (m_st[i] == 2) return i;
        return -1;
    endfunction

    function automatic int m_exec();
        for (int i = 0; i < NS; i++) if (m_st[i] == 3) return i;
        return -1;
    endfunction

    function automatic bit m_busy();
        for (int i = 0; i < NS; i++) if (m_st[i] != 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < NS; i++) begin
            m_st[i] = 0; m_op[i] = '0; m_ar[i] = 1'b0; m_br[i] = 1'b0;
            m_at[i] = '0; m_bt[i] = '0; m_ad[i] = '0; m_bd[i] = '0;
        end
    endtask

    task automatic check_outputs(input string req);
        int a, d;
        logic [NS-1:0] er;
        a = m_alloc();
        d = m_dsel();
        chk(req, "issue_free", 64'(issue_free), 64'(a >= 0));
        if (a >= 0) chk(req, "issue_tag", 64'(issue_tag), 64'(BT + a));
        chk(req, "disp_valid", 64'(disp_valid), 64'(d >= 0));
        if (d >= 0) begin
            chk(req, "disp_tag",  64'(disp_tag),  64'(BT + d));
            chk(req, "disp_op",   64'(disp_op),   64'(m_op[d]));
            chk(req, "disp_sink", 64'(disp_sink), 64'(m_ad[d]));
            chk(req, "disp_src",  64'(disp_src),  64'(m_bd[d]));
        end
        er = '0;
        for (int i = 0; i < NS; i++) er[i] = (m_st[i] == 3) || (i == d);
        chk(req, "bus_req", 64'(bus_req), 64'(er));
    endtask

    task automatic m_edge();
        int  a, d;
        bit  acc;
        logic hit;
        a   = m_alloc();
        d   = m_dsel();
        acc = issue_valid && (a >= 0);
        for (int i = 0; i < NS; i++) begin
            case (m_st[i])
                0: if (acc && a == i) begin
                    m_op[i] = issue_op;
                    m_at[i] = issue_sink_tag;
                    m_bt[i] = issue_src_tag;
                    if (issue_sink_rdy) begin m_ar[i] = 1'b1; m_ad[i] = issue_sink_data; end
                    else if (bus_valid && bus_tag == issue_sink_tag) begin m_ar[i] = 1'b1; m_ad[i] = bus_data; end
                    else m_ar[i] = 1'b0;
                    if (issue_src_rdy) begin m_br[i] = 1'b1; m_bd[i] = issue_src_data; end
                    else if (bus_valid && bus_tag == issue_src_tag) begin m_br[i] = 1'b1; m_bd[i] = bus_data; end
                    else m_br[i] = 1'b0;
                    m_st[i] = (m_ar[i] && m_br[i]) ? 2 : 1;
                end
                1: begin
                    hit = 1'b0;
                    if (!m_ar[i] && bus_valid && bus_tag == m_at[i]) begin m_ar[i] = 1'b1; m_ad[i] = bus_data; hit = 1'b1; end
                    if (!m_br[i] && bus_valid && bus_tag == m_bt[i]) begin m_br[i] = 1'b1; m_bd[i] = bus_data; hit = 1'b1; end
                    if (hit && m_ar[i] && m_br[i]) m_st[i] = 2;
                end
                2: if (d == i) m_st[i] = 3;
                3: if (bus_valid && bus_tag == TW'(BT + i)) m_st[i] = 0;
                default: ;
            endcase
        end
    endtask

    task automatic step(input string req);
        #1;
        check_outputs(req);
        @(posedge clk);
        m_edge();
        @(negedge clk);
    endtask

    task automatic set_issue(input logic v, input logic [OW-1:0] op,
                             input logic sr, input logic [TW-1:0] st, input logic [DW-1:0] sd,
                             input logic rr, input logic [TW-1:0] rt, input logic [DW-1:0] rd);
        issue_valid = v; issue_op = op;
        issue_sink_rdy = sr; issue_sink_tag = st; issue_sink_data = sd;
        issue_src_rdy = rr; issue_src_tag = rt; issue_src_data = rd;
    endtask

    task automatic set_bus(input logic v, input logic [TW-1:0] t, input logic [DW-1:0] d);
        bus_valid = v; bus_tag = t; bus_data = d;
    endtask

    task automatic idle();
        set_issue(1'b0, '0, 1'b0, '0, '0, 1'b0, '0, '0);
        set_bus(1'b0, '0, '0);
    endtask

    task automatic drain();
        int e;
        for (int k = 0; k < 300 && m_busy(); k++) begin
            set_issue(1'b0, '0, 1'b0, '0, '0, 1'b0, '0, '0);
            e = m_exec();
            if (e >= 0) set_bus(1'b1, TW'(BT + e), $urandom);
            else set_bus(1'b1, TW'(k % 12 + 1), $urandom);
            step("R9 drain");
        end
        idle();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int a, e;
        logic [TW-1:0] t1, t2;
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        idle();
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        chk("R1", "issue_free", 64'(issue_free), 64'd1);
        chk("R1", "issue_tag",  64'(issue_tag),  64'd10);
        chk("R1", "disp_valid", 64'(disp_valid), 64'd0);
        chk("R1", "bus_req",    64'(bus_req),    64'd0);
        @(negedge clk);

        // R4 and R7: operands given directly, dispatch next cycle
        set_issue(1'b1, 2'd1, 1'b1, 4'd0, 32'h11, 1'b1, 4'd0, 32'h22);
        step("R4 issue ready");
        idle();
        step("R7 dispatch");
        step("R9 request held");
        drain();

        // R5: two pending operands filled out of order
        set_issue(1'b1, 2'd2, 1'b0, 4'd3, '0, 1'b0, 4'd4, '0);
        step("R5 issue pending");
        idle(); set_bus(1'b1, 4'd4, 32'hA4);
        step("R5 source first");
        set_bus(1'b1, 4'd3, 32'hA3);
        step("R5 sink second");
        idle();
        step("R7 dispatch after capture");
        drain();

        // R6: match on the issue cycle
        set_issue(1'b1, 2'd3, 1'b0, 4'd5, '0, 1'b1, 4'd0, 32'h66);
        set_bus(1'b1, 4'd5, 32'h55);
        step("R6 same cycle capture");
        idle();
        step("R6 dispatch");
        drain();

        // R10: non-matching broadcast
        set_issue(1'b1, 2'd0, 1'b0, 4'd6, '0, 1'b1, 4'd0, 32'h1);
        step("R10 issue");
        idle(); set_bus(1'b1, 4'd7, 32'h77);
        step("R10 other tag");
        idle();
        step("R10 still waiting");
        set_bus(1'b1, 4'd6, 32'h60);
        step("R10 own tag later");
        drain();

        // R2, R3, R8: fill all stations, issue while full, release together
        for (int i = 0; i < NS; i++) begin
            set_issue(1'b1, OW'(i), 1'b0, 4'd2, '0, 1'b1, 4'd0, 32'(i + 100));
            step("R2 fill lowest free");
        end
        set_issue(1'b1, 2'd3, 1'b1, 4'd0, 32'hDEAD, 1'b1, 4'd0, 32'hBEEF);
        step("R3 issue while full");
        idle();
        step("R3 nothing changed");
        set_bus(1'b1, 4'd2, 32'h222);
        step("R8 common operand arrives");
        idle();
        for (int i = 0; i < NS + 1; i++) step("R8 lowest first one per cycle");
        drain();

        // random traffic
        for (int c = 0; c < 3000; c++) begin
            a = m_alloc();
            t1 = TW'($urandom_range(1, 12));
            t2 = TW'($urandom_range(1, 12));
            if (a >= 0 && t1 == TW'(BT + a)) t1 = 4'd1;
            if (a >= 0 && t2 == TW'(BT + a)) t2 = 4'd2;
            set_issue(1'($urandom_range(0, 1)), OW'($urandom),
                      1'($urandom_range(0, 1)), t1, $urandom,
                      1'($urandom_range(0, 1)), t2, $urandom);
            e = m_exec();
            if (e >= 0 && $urandom_range(0, 2) == 0) set_bus(1'b1, TW'(BT + e), $urandom);
            else if ($urandom_range(0, 1) == 0) set_bus(1'b1, TW'($urandom_range(1, 12)), $urandom);
            else set_bus(1'b0, '0, '0);
            step("R2 R5 R7 R8 R9 random");
        end
        drain();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule